// File: doc/BRIEF.md
# Interface-Clock Activity Power Controller

This block decides whether a clock-driven single-bit sensor is asleep or running. It does so by watching how fast its interface clock toggles, with no control pin involved. The interface clock is asynchronous to the block. It is brought into a free-running reference clock domain through a two-flop synchroniser, and its rising edges are counted over a fixed window of reference cycles.

At the end of each window the edge count is compared against two thresholds that are set by parameter:

- A count at or above the wake threshold takes a sleeping device awake.
- A count at or below the sleep threshold puts it back to sleep.
- Any count strictly between the two keeps the current mode.

A separate idle timer catches a clock that has stopped entirely, in either level, before the window closes.

After waking, the modulator core stays in reset and the data pin stays high impedance for a settling interval. Once that interval ends, the core is enabled. The data pin output-enable then follows the interface clock phase chosen by the edge-select input, so two sensors can share one data line, each driving on its own half-cycle.

Top module: `clkact_power_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `awake_o`, `core_en_o` and `data_oe_o` are all 0.
- R2: From sleep, a window whose rising-edge count is at least `WAKE_TH` sets `awake_o` at the next reference edge. A steadily fast clock therefore wakes the block within two windows plus synchroniser latency.
- R3: From sleep, window counts strictly between `SLEEP_TH` and `WAKE_TH` leave the block asleep.
- R4: In run mode, window counts strictly above `SLEEP_TH` (and a clock that keeps toggling) leave `core_en_o` at 1.
- R5: A window count at or below `SLEEP_TH` clears `awake_o`, `core_en_o` and `data_oe_o` at the next reference edge.
- R6: A clock that stops toggling, high or low, is declared idle after `STALL_CYC` reference cycles without a detected edge. The block then sleeps within a few cycles of that, without waiting for the window to end.
- R7: `core_en_o` rises exactly `SETTLE_CYC` reference cycles after `awake_o` rises. During those cycles `core_en_o` and `data_oe_o` stay 0.
- R8: In run mode `data_oe_o` is 1 exactly when the interface clock level equals `edge_sel_i`. With `edge_sel_i` = 0 the pin is driven while the clock is low; with 1, while it is high. Outside run mode `data_oe_o` is 0 at any clock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ifc_clk_i | input | 1 | Interface clock from the host, asynchronous |
| edge_sel_i | input | 1 | Half-cycle select for driving the data pin |
| awake_o | output | 1 | Mode flag: 1 when settling or running |
| core_en_o | output | 1 | Modulator core enable (0 holds it in reset) |
| data_oe_o | output | 1 | Output-enable of the tristate data pin |

## Verification
The bench builds the block with a 128-cycle window, a wake threshold of 16 and a sleep threshold of 3. It also uses a 40-cycle idle timeout and a 20-cycle settling delay. With these values, an interface clock of period 4, 16 and 128 reference cycles falls clearly above, between and below the thresholds, so wake, both kinds of hysteresis hold, and sleep can each be reached in a few windows. Because the idle timeout is well below the window length, a stopped clock can only be caught in time by the timeout path. The short settling delay lets the exact cycle count from wake to core enable be measured directly.

// File: rtl/clkact_pkg.sv
package clkact_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'd0,
        MODE_SETTLE = 2'd1,
        MODE_RUN    = 2'd2
    } mode_e;

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    // newest synchronised sample high, previous one low
    assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

    // R2
    rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/rate_meter.sv
module rate_meter #(
    parameter int WIN_CYC   = 1000,
    parameter int STALL_CYC = 400,
    parameter int CNT_W     = $clog2(WIN_CYC + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] count_o,
    output logic             stall_o
);
    localparam int WIN_W  = $clog2(WIN_CYC);
    localparam int IDLE_W = $clog2(STALL_CYC);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_CYC - 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(STALL_CYC - 1);

    typedef struct packed {
        logic [WIN_W-1:0]  win;
        logic [CNT_W-1:0]  edges;
        logic [IDLE_W-1:0] idle;
        logic              valid;
        logic [CNT_W-1:0]  result;
    } meter_t;

    meter_t m_d, m_q;

    always_comb begin
        m_d       = m_q;
        m_d.valid = 1'b0;

        // idle timer: cleared by every edge, saturates at its limit
        if (edge_i)                 m_d.idle = '0;
        else if (m_q.idle != IDLE_LAST) m_d.idle = m_q.idle + 1'b1;

        // window: close it, publish the count, start the next one
        if (m_q.win == WIN_LAST) begin
            m_d.win    = '0;
            m_d.valid  = 1'b1;
            m_d.result = m_q.edges;
            m_d.edges  = edge_i ? CNT_W'(1) : '0;
        end else begin
            m_d.win = m_q.win + 1'b1;
            if (edge_i) m_d.edges = m_q.edges + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) m_q <= '0;
        else         m_q <= m_d;
    end

    assign valid_o = m_q.valid;
    assign count_o = m_q.result;
    assign stall_o = (m_q.idle == IDLE_LAST);

    // R2
    count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (count_o <= CNT_W'(WIN_CYC)));

    // R6
    stall_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_i |=> !stall_o);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import clkact_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int WAKE_TH    = 30,
    parameter int SLEEP_TH   = 7,
    parameter int SETTLE_CYC = 3500
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             stall_i,
    output logic             awake_o,
    output logic             core_en_o,
    output logic             drive_en_o
);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE_CYC - 1);

    typedef struct packed {
        mode_e            mode;
        logic [SET_W-1:0] hold;
    } fsm_t;

    fsm_t f_d, f_q;
    logic go_fast, go_slow;

    assign go_fast = valid_i && (count_i >= CNT_W'(WAKE_TH));
    assign go_slow = stall_i || (valid_i && (count_i <= CNT_W'(SLEEP_TH)));

    always_comb begin
        f_d = f_q;
        if (go_slow) begin
            f_d.mode = MODE_SLEEP;
            f_d.hold = '0;
        end else begin
            unique case (f_q.mode)
                MODE_SLEEP: begin
                    if (go_fast) begin
                        f_d.mode = MODE_SETTLE;
                        f_d.hold = SET_LOAD;
                    end
                end
                MODE_SETTLE: begin
                    if (f_q.hold == '0) f_d.mode = MODE_RUN;
                    else                f_d.hold = f_q.hold - 1'b1;
                end
                MODE_RUN: ;
                default: f_d.mode = MODE_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '{mode: MODE_SLEEP, hold: '0};
        else         f_q <= f_d;
    end

    assign awake_o    = (f_q.mode != MODE_SLEEP);
    assign core_en_o  = (f_q.mode == MODE_RUN);
    assign drive_en_o = (f_q.mode == MODE_RUN);

    // R2
    wake_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!awake_o && go_fast && !stall_i) |=> (awake_o && !core_en_o));

    // R3
    hold_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!awake_o && !go_fast) |=> !awake_o);

    // R4
    hold_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_en_o && !go_slow) |=> core_en_o);

    // R5
    fall_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && count_i <= CNT_W'(SLEEP_TH)) |=> (!awake_o && !core_en_o && !drive_en_o));

    // R6
    stall_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_i |=> !awake_o);

    // R7
    settle_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_en_o) |-> $past(awake_o));

endmodule

// File: rtl/clkact_power_ctrl.sv
module clkact_power_ctrl #(
    parameter int WIN_CYC     = 1000,
    parameter int STALL_CYC   = 400,
    parameter int WAKE_TH     = 30,
    parameter int SLEEP_TH    = 7,
    parameter int SETTLE_CYC  = 3500,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk_i,
    input  logic rst_ni,
    input  logic ifc_clk_i,
    input  logic edge_sel_i,
    output logic awake_o,
    output logic core_en_o,
    output logic data_oe_o
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);

    logic             rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_count;
    logic             stall;
    logic             drive_en;

    ifc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (ref_clk_i),
        .rst_ni  (rst_ni),
        .async_i (ifc_clk_i),
        .rise_o  (rise)
    );

    rate_meter #(
        .WIN_CYC   (WIN_CYC),
        .STALL_CYC (STALL_CYC),
        .CNT_W     (CNT_W)
    ) u_meter (
        .clk_i   (ref_clk_i),
        .rst_ni  (rst_ni),
        .edge_i  (rise),
        .valid_o (meas_valid),
        .count_o (meas_count),
        .stall_o (stall)
    );

    mode_fsm #(
        .CNT_W      (CNT_W),
        .WAKE_TH    (WAKE_TH),
        .SLEEP_TH   (SLEEP_TH),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk_i      (ref_clk_i),
        .rst_ni     (rst_ni),
        .valid_i    (meas_valid),
        .count_i    (meas_count),
        .stall_i    (stall),
        .awake_o    (awake_o),
        .core_en_o  (core_en_o),
        .drive_en_o (drive_en)
    );

    // drive only on the chosen half of the interface clock
    assign data_oe_o = drive_en & (ifc_clk_i == edge_sel_i);

    // R8
    oe_gate_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
        !core_en_o |-> !data_oe_o);

endmodule

// File: tb/clkact_power_ctrl_tb.sv
`timescale 1ns/1ps
module clkact_power_ctrl_tb;
    localparam int WIN    = 128;
    localparam int STALL  = 40;
    localparam int WAKE   = 16;
    localparam int SLP    = 3;
    localparam int SETTLE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ifc = 1'b0;
    logic sel = 1'b0;
    logic awake, core_en, oe;

    bit run = 1'b0;
    int half_ns = 20;
    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    initial begin
        forever begin
            if (run) begin
                #(half_ns * 1ns);
                if (run) ifc = ~ifc;
            end else begin
                #10ns;
            end
        end
    end

    clkact_power_ctrl #(
        .WIN_CYC(WIN), .STALL_CYC(STALL), .WAKE_TH(WAKE),
        .SLEEP_TH(SLP), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)
    ) u_dut (
        .ref_clk_i(clk), .rst_ni(rst_n), .ifc_clk_i(ifc), .edge_sel_i(sel),
        .awake_o(awake), .core_en_o(core_en), .data_oe_o(oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // returns cycles taken until awake, or -1
    task automatic wait_awake(output int n);
        n = -1;
        for (int i = 0; i < 4 * WIN; i++) begin
            @(negedge clk);
            if (awake) begin n = i; break; end
        end
    endtask

    task automatic t_reset();
        cycles(3);
        chk(awake == 1'b0,   "R1 awake in reset", awake, 0);
        chk(core_en == 1'b0, "R1 core_en in reset", core_en, 0);
        chk(oe == 1'b0,      "R1 data_oe in reset", oe, 0);
        rst_n = 1'b1;
        cycles(2);
        chk(awake == 1'b0 && core_en == 1'b0, "R1 after release", awake, 0);
    endtask

    task automatic t_mid_from_sleep();
        int seen = 0;
        half_ns = 80; run = 1'b1;
        for (int i = 0; i < 4 * WIN; i++) begin
            @(negedge clk);
            if (awake) seen++;
        end
        chk(seen == 0, "R3 mid rate keeps sleep", seen, 0);
    endtask

    task automatic t_wake_settle();
        int n;
        int settle = 0;
        int oe_bad = 0;
        half_ns = 20;
        wait_awake(n);
        chk(n >= 0 && n <= 2 * WIN + 8, "R2 fast clock wakes", n, 2 * WIN);
        while (awake && !core_en && settle < 4 * SETTLE) begin
            settle++;
            if (oe) oe_bad++;
            @(negedge clk);
        end
        chk(settle == SETTLE, "R7 settle length", settle, SETTLE);
        chk(oe_bad == 0, "R7 oe low while settling", oe_bad, 0);
        chk(core_en == 1'b1, "R7 core enabled after settle", core_en, 1);
    endtask

    task automatic t_half_cycle();
        sel = 1'b0;
        @(posedge ifc); #2;
        chk(oe == 1'b0, "R8 sel0 clock high", oe, 0);
        @(negedge ifc); #2;
        chk(oe == 1'b1, "R8 sel0 clock low", oe, 1);
        sel = 1'b1;
        @(posedge ifc); #2;
        chk(oe == 1'b1, "R8 sel1 clock high", oe, 1);
        @(negedge ifc); #2;
        chk(oe == 1'b0, "R8 sel1 clock low", oe, 0);
    endtask

    task automatic t_mid_active();
        int off = 0;
        half_ns = 80;
        for (int i = 0; i < 4 * WIN; i++) begin
            @(negedge clk);
            if (!core_en) off++;
        end
        chk(off == 0, "R4 mid rate keeps run", off, 0);
    endtask

    task automatic t_slow();
        half_ns = 640;
        cycles(3 * WIN);
        chk(awake == 1'b0,   "R5 slow clock sleeps", awake, 0);
        chk(core_en == 1'b0, "R5 core off in sleep", core_en, 0);
        chk(oe == 1'b0,      "R5 oe off in sleep", oe, 0);
    endtask

    task automatic t_stall(input bit stop_high);
        int n;
        int dt = 0;
        half_ns = 20;
        wait_awake(n);
        cycles(SETTLE + 4);
        chk(core_en == 1'b1, "R6 running before stop", core_en, 1);
        sel = stop_high;
        if (stop_high) @(posedge ifc); else @(negedge ifc);
        run = 1'b0;
        while (awake && dt < 2 * WIN) begin
            @(negedge clk);
            dt++;
        end
        chk(dt >= STALL - 8 && dt <= STALL + 4, "R6 idle timeout delay", dt, STALL);
        chk(oe == 1'b0 && core_en == 1'b0, "R6 outputs off after stop", oe, 0);
        cycles(WIN);
        chk(ifc == stop_high && oe == 1'b0, "R8 oe off with level matching sel", oe, 0);
        run = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", total, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mid_from_sleep();
        t_wake_settle();
        t_half_cycle();
        t_mid_active();
        t_slow();
        t_stall(1'b0);
        t_stall(1'b1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

endmodule